// File: doc/BRIEF.md
# Word/Byte Integer ALU with Condition Flags

This block is the integer execution unit of a small 16-bit processor. It takes an operation code, a byte/word select, a source operand and a destination operand. It computes a result without any clock delay and states whether that result is to be written back. A four-bit condition register holds the flags negative (N), zero (Z), signed overflow (V) and carry/borrow (C). The register changes only on the clock edge at which the update strobe is high.

The block covers moves, add, subtract, compare, test, clear, increment, decrement, one's complement and two's-complement negate. It also has two flag operations that set or clear any chosen subset of the condition bits. Compare and test change only the flags. In byte mode the operation works on the low eight bits. The upper byte of the destination passes through to the result unchanged, and the flags describe the low byte alone.

Top module: `wb_alu`

## Requirements
- R1: While `rst` is high at a clock edge, the flag register becomes 0000. `flags_o` bit order is {N,Z,V,C}, bit 3 to bit 0.
- R2: `res_o` and `wr_o` follow the inputs combinationally. `flags_o` loads new values only on a clock edge with `upd_i`=1 and otherwise holds its value.
- R3: The `op_i` codes are: 0 MOV, 1 ADD, 2 SUB, 3 CMP, 4 TST, 5 CLR, 6 INC, 7 DEC, 8 COM, 9 NEG, 10 SETF, 11 CLRF. Codes 12 to 15 are reserved: they output `res_o`=`dst_i` and `wr_o`=0 and leave every flag unchanged.
- R4: N is the sign bit of the result and Z is 1 exactly when the result is zero. This applies to every operation except SETF, CLRF and the reserved codes.
- R5: ADD yields dst+src. C is the carry out of the top bit and V is signed overflow.
- R6: SUB yields dst−src. C is 1 when a borrow occurs (dst<src unsigned) and V is signed overflow.
- R7: CMP computes src−dst, which is the reverse of the SUB order, and sets N, Z, V and C the way SUB does for that order. Its `wr_o` is 0.
- R8: TST sets N and Z from dst, forces V=0 and C=0, and drives `wr_o`=0 with `res_o`=dst.
- R9: MOV yields src with V=0 and C unchanged. CLR yields 0 with V=0 and C=0. COM yields ~dst with V=0 and C=1.
- R10: INC yields dst+1 and DEC yields dst−1. V flags signed overflow and C is left unchanged.
- R11: NEG yields 0−dst. C is 1 unless dst is zero, and V is 1 only when dst is the most negative value.
- R12: With `byte_i`=1 the operation uses bits 7:0 only. `res_o[15:8]` equals `dst_i[15:8]`, N is bit 7, Z tests bits 7:0, and C and V come from the 8-bit operation.
- R13: SETF sets each flag whose bit is 1 in `src_i[3:0]` (same {N,Z,V,C} order). CLRF clears each such flag. Unmasked flags keep their value, and both operations drive `wr_o`=0 and `res_o`=`dst_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code |
| byte_i | input | 1 | 1 selects byte mode, 0 selects word mode |
| src_i | input | 16 | Source operand; bits 3:0 are the flag mask for SETF/CLRF |
| dst_i | input | 16 | Destination operand |
| upd_i | input | 1 | Flag-update strobe |
| res_o | output | 16 | Result |
| wr_o | output | 1 | Write-back enable |
| flags_o | output | 4 | Condition register {N,Z,V,C} |

## Verification
The bench runs compare with operands whose difference has a different sign and borrow in each subtraction order. A design that reuses the SUB order would report FFFE with a borrow where 0002 with no borrow is expected. INC of FFFF and DEC of 8000 are run with a known C, which catches a design that lets the adder carry leak into C, and INC of 7FFF checks signed overflow. Byte-mode cases use an upper byte that would change a word-width flag: 0100 tests zero in byte mode but not in word mode, and F0+20 carries only at eight bits. TST of 8000 with C and V set up beforehand catches a design that keeps V and C, and dropping the strobe shows whether the flag register holds.

// File: rtl/wbalu_pkg.sv
package wbalu_pkg;

    parameter int unsigned DATA_W = 16;
    parameter int unsigned BYTE_W = 8;
    parameter int unsigned FLAG_W = 4;
    parameter int unsigned OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_MOV  = 4'd0,
        OP_ADD  = 4'd1,
        OP_SUB  = 4'd2,
        OP_CMP  = 4'd3,
        OP_TST  = 4'd4,
        OP_CLR  = 4'd5,
        OP_INC  = 4'd6,
        OP_DEC  = 4'd7,
        OP_COM  = 4'd8,
        OP_NEG  = 4'd9,
        OP_SETF = 4'd10,
        OP_CLRF = 4'd11
    } alu_op_e;

    // Flag word, bit 3 down to bit 0
    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } nzvc_t;

    // Request presented to the adder lanes
    typedef struct packed {
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
        logic              sub;
    } addsub_req_t;

    function automatic logic op_uses_adder(input logic [OP_W-1:0] op);
        case (op)
            OP_ADD, OP_SUB, OP_CMP, OP_INC, OP_DEC, OP_NEG: return 1'b1;
            default:                                        return 1'b0;
        endcase
    endfunction

    function automatic logic op_writes(input logic [OP_W-1:0] op);
        case (op)
            OP_MOV, OP_ADD, OP_SUB, OP_CLR,
            OP_INC, OP_DEC, OP_COM, OP_NEG: return 1'b1;
            default:                        return 1'b0;
        endcase
    endfunction

    function automatic logic op_sets_nz(input logic [OP_W-1:0] op);
        return (op <= OP_NEG);
    endfunction

endpackage

// File: rtl/wbalu_lane.sv
module wbalu_lane #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         carry_o,
    output logic         ovf_o
);
    logic [W-1:0] b_eff;
    logic [W:0]   wide;

    always_comb begin
        b_eff   = b_i ^ {W{sub_i}};
        wide    = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
        sum_o   = wide[W-1:0];
        carry_o = wide[W];
        // Signed overflow: equal operand signs, different result sign
        ovf_o   = (a_i[W-1] == b_eff[W-1]) && (wide[W-1] != a_i[W-1]);
    end
endmodule

// File: rtl/wbalu_core.sv
module wbalu_core
    import wbalu_pkg::*;
#(
    parameter int unsigned DATA_W = wbalu_pkg::DATA_W,
    parameter int unsigned BYTE_W = wbalu_pkg::BYTE_W
) (
    input  logic [OP_W-1:0]   op,
    input  logic              byte_sel,
    input  logic [DATA_W-1:0] src,
    input  logic [DATA_W-1:0] dst,
    output logic [DATA_W-1:0] res,
    output logic              wr,
    output nzvc_t             fl_new,
    output nzvc_t             fl_keep
);
    localparam int unsigned NLANE = 2;   // lane 0 word, lane 1 byte

    addsub_req_t       req;
    logic [DATA_W-1:0] lane_sum [NLANE];
    logic [NLANE-1:0]  lane_c;
    logic [NLANE-1:0]  lane_v;
    logic [DATA_W-1:0] raw;
    logic              sgn, zer, cy, ov, cb;
    nzvc_t             mask;

    // Operand steering for the adder
    always_comb begin
        req.a   = dst;
        req.b   = src;
        req.sub = 1'b0;
        case (op)
            OP_SUB: req.sub = 1'b1;
            OP_CMP: begin req.a = src; req.b = dst; req.sub = 1'b1; end
            OP_INC: req.b = DATA_W'(1);
            OP_DEC: begin req.b = DATA_W'(1); req.sub = 1'b1; end
            OP_NEG: begin req.a = '0; req.b = dst; req.sub = 1'b1; end
            default: ;
        endcase
    end

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        localparam int unsigned LW = (g == 0) ? DATA_W : BYTE_W;
        logic [LW-1:0] s_l;
        wbalu_lane #(.W(LW)) u_lane (
            .a_i    (req.a[LW-1:0]),
            .b_i    (req.b[LW-1:0]),
            .sub_i  (req.sub),
            .sum_o  (s_l),
            .carry_o(lane_c[g]),
            .ovf_o  (lane_v[g])
        );
        assign lane_sum[g] = DATA_W'(s_l);
    end

    // Raw result before byte merge
    always_comb begin
        raw = dst;
        if (op_uses_adder(op)) begin
            raw = byte_sel ? lane_sum[1] : lane_sum[0];
        end else begin
            case (op)
                OP_MOV:  raw = src;
                OP_CLR:  raw = '0;
                OP_COM:  raw = ~dst;
                default: raw = dst;
            endcase
        end
    end

    always_comb begin
        res  = byte_sel ? {dst[DATA_W-1:BYTE_W], raw[BYTE_W-1:0]} : raw;
        wr   = op_writes(op);
        sgn  = byte_sel ? res[BYTE_W-1] : res[DATA_W-1];
        zer  = byte_sel ? (res[BYTE_W-1:0] == '0) : (res == '0);
        cy   = byte_sel ? lane_c[1] : lane_c[0];
        ov   = byte_sel ? lane_v[1] : lane_v[0];
        cb   = cy ^ req.sub;      // subtraction reports borrow
        mask = nzvc_t'(src[FLAG_W-1:0]);
    end

    // Flag decode: value to load and bits to preserve
    always_comb begin
        fl_new  = '{n: sgn, z: zer, v: 1'b0, c: 1'b0};
        fl_keep = '0;
        case (op)
            OP_MOV:                         fl_keep.c = 1'b1;
            OP_ADD, OP_SUB, OP_CMP, OP_NEG: begin fl_new.v = ov; fl_new.c = cb; end
            OP_INC, OP_DEC:                 begin fl_new.v = ov; fl_keep.c = 1'b1; end
            OP_COM:                         fl_new.c = 1'b1;
            OP_TST, OP_CLR:                 ;
            OP_SETF: begin fl_new = '1; fl_keep = ~mask; end
            OP_CLRF: begin fl_new = '0; fl_keep = ~mask; end
            default:                        fl_keep = '1;
        endcase
        if (!op_sets_nz(op) && op != OP_SETF && op != OP_CLRF) fl_keep = '1;
    end
endmodule

// File: rtl/wbalu_flags.sv
module wbalu_flags #(
    parameter int unsigned FLAG_W = wbalu_pkg::FLAG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_i,
    input  logic [FLAG_W-1:0] new_i,
    input  logic [FLAG_W-1:0] keep_i,
    output logic [FLAG_W-1:0] q_o
);
    for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                q_o[i] <= 1'b0;
            else if (upd_i && !keep_i[i])
                q_o[i] <= new_i[i];
        end
    end
endmodule

// File: rtl/wb_alu.sv
module wb_alu
    import wbalu_pkg::*;
#(
    parameter int unsigned DATA_W = wbalu_pkg::DATA_W,
    parameter int unsigned BYTE_W = wbalu_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OP_W-1:0]   op_i,
    input  logic              byte_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic [DATA_W-1:0] dst_i,
    input  logic              upd_i,
    output logic [DATA_W-1:0] res_o,
    output logic              wr_o,
    output logic [FLAG_W-1:0] flags_o
);
    nzvc_t fl_new, fl_keep;

    wbalu_core #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_core (
        .op      (op_i),
        .byte_sel(byte_i),
        .src     (src_i),
        .dst     (dst_i),
        .res     (res_o),
        .wr      (wr_o),
        .fl_new  (fl_new),
        .fl_keep (fl_keep)
    );

    wbalu_flags #(.FLAG_W(FLAG_W)) u_flags (
        .clk   (clk),
        .rst   (rst),
        .upd_i (upd_i),
        .new_i (fl_new),
        .keep_i(fl_keep),
        .q_o   (flags_o)
    );

    AST_HOLD_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (rst)
        !upd_i |=> $stable(flags_o)); // R2

    AST_COMPARE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_CMP || op_i == OP_TST) |-> !wr_o); // R7

    AST_TEST_CLEARS_VC: assert property (@(posedge clk) disable iff (rst)
        (upd_i && op_i == OP_TST) |=> (flags_o[1:0] == 2'b00)); // R8

    AST_CLEAR_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (upd_i && op_i == OP_CLR) |=> (flags_o == 4'b0100)); // R9

    AST_STEP_KEEPS_C: assert property (@(posedge clk) disable iff (rst)
        (upd_i && (op_i == OP_INC || op_i == OP_DEC)) |=> (flags_o[0] == $past(flags_o[0]))); // R10

    AST_RESERVED_INERT: assert property (@(posedge clk) disable iff (rst)
        (op_i > OP_CLRF) |=> $stable(flags_o)); // R3
endmodule

// File: tb/wb_alu_test.sv
module wb_alu_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  op;
    logic        bsel;
    logic [15:0] src, dst;
    logic        upd;
    logic [15:0] res;
    logic        wr;
    logic [3:0]  flags;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    wb_alu uut (
        .clk(clk), .rst(rst), .op_i(op), .byte_i(bsel), .src_i(src),
        .dst_i(dst), .upd_i(upd), .res_o(res), .wr_o(wr), .flags_o(flags)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Drive one operation, check result and write enable before the edge,
    // then the flags after it.
    task automatic run(input string tag, input logic [3:0] o, input logic b,
                       input logic [15:0] s, input logic [15:0] d, input logic u,
                       input logic [15:0] er, input logic ew, input logic [3:0] ef);
        @(negedge clk);
        op = o; bsel = b; src = s; dst = d; upd = u;
        #2;
        chk({tag, " result"}, res, er);
        chk({tag, " write"}, 16'(wr), 16'(ew));
        @(posedge clk);
        #2;
        chk({tag, " flags"}, 16'(flags), 16'(ef));
    endtask

    task automatic t_reset;
        rst = 1'b1; op = 4'd0; bsel = 1'b0; src = '0; dst = '0; upd = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        chk("R1 reset flags", 16'(flags), 16'h0000);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_add;
        run("R5 add overflow R4", 4'd1, 0, 16'h3000, 16'h6000, 1, 16'h9000, 1, 4'b1010);
        run("R5 add carry", 4'd1, 0, 16'h6000, 16'hB000, 1, 16'h1000, 1, 4'b0001);
    endtask

    task automatic t_sub_cmp;
        run("R6 sub borrow", 4'd2, 0, 16'h0007, 16'h0005, 1, 16'hFFFE, 1, 4'b1001);
        run("R6 sub overflow", 4'd2, 0, 16'h0001, 16'h8000, 1, 16'h7FFF, 1, 4'b0010);
        run("R7 cmp order", 4'd3, 0, 16'h0007, 16'h0005, 1, 16'h0002, 0, 4'b0000);
        run("R7 cmp equal", 4'd3, 0, 16'h0005, 16'h0005, 1, 16'h0000, 0, 4'b0100);
    endtask

    task automatic t_tst_mov;
        run("R13 setf C", 4'd10, 0, 16'h0001, 16'h1234, 1, 16'h1234, 0, 4'b0101);
        run("R13 setf VC", 4'd10, 0, 16'h0003, 16'h0000, 1, 16'h0000, 0, 4'b0111);
        run("R8 tst clears VC", 4'd4, 0, 16'h0000, 16'h8000, 1, 16'h8000, 0, 4'b1000);
        run("R13 setf VC again", 4'd10, 0, 16'h0003, 16'h0000, 1, 16'h0000, 0, 4'b1011);
        run("R9 mov zero keeps C", 4'd0, 0, 16'h0000, 16'h5555, 1, 16'h0000, 1, 4'b0101);
        run("R9 mov negative", 4'd0, 0, 16'h8001, 16'h5555, 1, 16'h8001, 1, 4'b1001);
        run("R9 clr", 4'd5, 0, 16'h0000, 16'h7777, 1, 16'h0000, 1, 4'b0100);
        run("R9 com", 4'd8, 0, 16'h0000, 16'h00FF, 1, 16'hFF00, 1, 4'b1001);
    endtask

    task automatic t_incdec;
        run("R10 inc overflow", 4'd6, 0, 16'h0000, 16'h7FFF, 1, 16'h8000, 1, 4'b1011);
        run("R10 dec of zero", 4'd7, 0, 16'h0000, 16'h0000, 1, 16'hFFFF, 1, 4'b1001);
        run("R10 dec of -2", 4'd7, 0, 16'h0000, 16'hFFFE, 1, 16'hFFFD, 1, 4'b1001);
        run("R10 dec overflow", 4'd7, 0, 16'h0000, 16'h8000, 1, 16'h7FFF, 1, 4'b0011);
        run("R13 clrf C", 4'd11, 0, 16'h0001, 16'h0000, 1, 16'h0000, 0, 4'b0010);
        run("R10 inc wrap keeps C", 4'd6, 0, 16'h0000, 16'hFFFF, 1, 16'h0000, 1, 4'b0100);
    endtask

    task automatic t_neg;
        run("R11 neg one", 4'd9, 0, 16'h0000, 16'h0001, 1, 16'hFFFF, 1, 4'b1001);
        run("R11 neg zero", 4'd9, 0, 16'h0000, 16'h0000, 1, 16'h0000, 1, 4'b0100);
        run("R11 neg most negative", 4'd9, 0, 16'h0000, 16'h8000, 1, 16'h8000, 1, 4'b1011);
    endtask

    task automatic t_byte;
        run("R12 byte add overflow", 4'd1, 1, 16'hAB20, 16'h1270, 1, 16'h1290, 1, 4'b1010);
        run("R12 byte add carry", 4'd1, 1, 16'h0020, 16'h00F0, 1, 16'h0010, 1, 4'b0001);
        run("R12 byte tst zero", 4'd4, 1, 16'h0000, 16'h0100, 1, 16'h0100, 0, 4'b0100);
        run("R12 byte sub borrow", 4'd2, 1, 16'h0001, 16'h3400, 1, 16'h34FF, 1, 4'b1001);
        run("R12 byte mov", 4'd0, 1, 16'h0080, 16'h5600, 1, 16'h5680, 1, 4'b1001);
        run("R12 byte clr", 4'd5, 1, 16'h0000, 16'h34FF, 1, 16'h3400, 1, 4'b0100);
        run("R12 byte dec overflow", 4'd7, 1, 16'h0000, 16'h0080, 1, 16'h007F, 1, 4'b0010);
    endtask

    task automatic t_strobe;
        run("R2 add no strobe", 4'd1, 0, 16'h3000, 16'h6000, 0, 16'h9000, 1, 4'b0010);
        run("R2 clr no strobe", 4'd5, 0, 16'h0000, 16'h1111, 0, 16'h0000, 1, 4'b0010);
    endtask

    task automatic t_flagops;
        run("R13 clrf all", 4'd11, 0, 16'h000F, 16'h0000, 1, 16'h0000, 0, 4'b0000);
        run("R13 setf Z", 4'd10, 0, 16'h0004, 16'h0000, 1, 16'h0000, 0, 4'b0100);
        run("R13 setf N", 4'd10, 0, 16'h0008, 16'h0000, 1, 16'h0000, 0, 4'b1100);
        run("R13 clrf Z", 4'd11, 0, 16'h0004, 16'h0000, 1, 16'h0000, 0, 4'b1000);
    endtask

    task automatic t_reserved;
        run("R3 reserved 12", 4'd12, 0, 16'hFFFF, 16'hABCD, 1, 16'hABCD, 0, 4'b1000);
        run("R3 reserved 15", 4'd15, 1, 16'h000F, 16'h0000, 1, 16'h0000, 0, 4'b1000);
    endtask

    initial begin
        t_reset;
        t_add;
        t_sub_cmp;
        t_tst_mov;
        t_incdec;
        t_neg;
        t_byte;
        t_strobe;
        t_flagops;
        t_reserved;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule